// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master

This block is a master-only synchronous serial port. The host places transmit words into an eight-deep transmit queue and takes received words from an eight-deep receive queue. A single shift engine runs each frame in one of three formats, chosen by a control input:

- a select-framed format with programmable clock polarity and phase;
- a frame-pulse format, in which a one-bit-period strobe comes before the data;
- a command/response format, in which an 8-bit command goes out, one turnaround bit follows, and a reply word is then clocked in.

The frame length can be set from 4 to 16 bits. The serial clock is derived from the system clock through a programmable divider. A loopback switch feeds the serial output back to the receive path. Four interrupt sources can each be masked, and a combined request is the OR of the enabled sources.

The engine is a six-state machine:

- `ST_IDLE` waits for a transmit word. When the transmit queue is non-empty it pops one word and latches the frame settings. It then goes to `ST_PULSE` in the frame-pulse format, or to `ST_SEND` otherwise.
- `ST_PULSE` lasts one bit period and then goes to `ST_SEND`.
- `ST_SEND` shifts bits out, most significant first. When the last bit ends it goes to `ST_TURN` in the command/response format, or to `ST_DONE` otherwise.
- `ST_TURN` is the one idle bit. It then goes to `ST_RECV`.
- `ST_RECV` clocks in the reply bits. After the last one it goes to `ST_DONE`.
- `ST_DONE` pushes the received word into the receive queue and returns to `ST_IDLE`.

Top module: `sync_serial_master`

## Requirements
- R1: After reset both queues are empty. The status outputs read tx-empty 1, tx-not-full 1, rx-not-empty 0, rx-full 0 and busy 0. With the select-framed format and polarity 0 chosen, the serial clock idles at 0 and the select line at 1.
- R2: Format code 0 (code 3 behaves the same) gives select-framed transfers. The select line is held low for the whole frame. The serial clock idles at the polarity value. Data leaves most significant bit first, one bit per sample edge, and there are exactly N sample edges. The sample edge is rising when polarity equals phase and falling otherwise.
- R3: Format code 1 gives frame-pulse transfers. The frame line is high for exactly one bit period just before the first data bit and low at all other times. The serial clock idles low and is high in the first half of each bit.
- R4: Format code 2 gives command/response transfers. The low 8 bits of the transmit word are sent most significant first on rising clock edges. One idle bit follows, with the output at 0. N bits are then sampled from the serial input on rising clock edges, and the resulting word is pushed into the receive queue.
- R5: The size input holds the frame length minus one; values 0 to 2 give 4 bits. Transmit bits above the frame length are ignored, and receive bits above it read as zero.
- R6: With loopback set, the receive path samples the serial output instead of the serial input. In formats 0 and 1 the received word then equals the low N bits of the sent word.
- R7: Each queue holds 8 words. A write to a full transmit queue is dropped. tx-not-full is 0 exactly when the queue holds 8 words.
- R8: One bit period lasts 2*(divider+1) system clock cycles.
- R9: Interrupt bit 0 is raised while the transmit queue holds 4 or fewer words. Interrupt bit 1 is raised while the receive queue holds 4 or more words. Each interrupt output is its raw source ANDed with its enable bit, and the combined output is the OR of the four outputs.
- R10: Interrupt bit 2 rises when the receive queue is non-empty and has seen neither a push nor a pop for 64*(divider+1) system cycles. A pop or push restarts that count.
- R11: Interrupt bit 3 is set when a received word arrives while the receive queue is full. That word is discarded. The bit stays set until the clear input is pulsed.
- R12: A new frame starts by itself whenever the transmit queue is non-empty, so queued words go out back to back. Busy is 1 while a frame runs or while words are waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wr | input | 1 | Push tx_wdata into the transmit queue |
| tx_wdata | input | 16 | Transmit word |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_rdata | output | 16 | Head of the receive queue |
| cfg_fmt | input | 2 | Format: 0 select-framed, 1 frame-pulse, 2 command/response |
| cfg_size | input | 4 | Frame length minus one |
| cfg_div | input | 8 | Clock divider; half-bit time is cfg_div+1 cycles |
| cfg_cpol | input | 1 | Clock idle level in format 0 |
| cfg_cpha | input | 1 | Clock phase in format 0 |
| cfg_loop | input | 1 | Loop serial output to receive path |
| cfg_irq_en | input | 4 | Per-source interrupt enables |
| ovr_clr | input | 1 | Clears the overrun interrupt |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sfrm | output | 1 | Select (active low) or frame pulse (active high) |
| sdi | input | 1 | Serial data in |
| st_tx_empty | output | 1 | Transmit queue empty |
| st_tx_not_full | output | 1 | Transmit queue has room |
| st_rx_not_empty | output | 1 | Receive queue holds data |
| st_rx_full | output | 1 | Receive queue full |
| st_busy | output | 1 | Frame running or words pending |
| irq | output | 4 | Masked interrupt requests |
| irq_any | output | 1 | OR of the masked requests |

## Verification
Some properties are checked by assertions on every cycle:

- the half-bit counter stays within the divider;
- the turnaround bit always leads into reception;
- the pulse state is used only in the frame-pulse format;
- queue levels stay within the depth;
- the overrun flag holds until it is cleared;
- the timeout flag is never raised while the receive queue is empty;
- a pending word always starts a frame.

Other behaviour appears only in the bench scenarios: the serial bit order on the line, the edge chosen for each polarity and phase, the pulse width, the command/reply exchange, the bit-period timing, which word a full queue drops, and the timeout delay.

// File: rtl/ssm_pkg.sv
`timescale 1ns/1ps
package ssm_pkg;

    typedef enum logic [1:0] {
        FMT_SPI   = 2'd0,
        FMT_DSP   = 2'd1,
        FMT_MWIRE = 2'd2
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_SEND,
        ST_TURN,
        ST_RECV,
        ST_DONE
    } eng_state_e;

    localparam int IRQ_TXLOW  = 0;
    localparam int IRQ_RXHIGH = 1;
    localparam int IRQ_TOUT   = 2;
    localparam int IRQ_OVR    = 3;
    localparam int NIRQ       = 4;

    function automatic fmt_e decode_fmt(input logic [1:0] code);
        unique case (code)
            2'd1:    return FMT_DSP;
            2'd2:    return FMT_MWIRE;
            default: return FMT_SPI;
        endcase
    endfunction

endpackage

// File: rtl/ssm_fifo.sv
`timescale 1ns/1ps
module ssm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;
    logic         push_ok, pop_ok;

    assign level   = wp - rp;
    assign full    = (level == (AW+1)'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push_ok) wp <= wp + 1'b1;
            if (pop_ok)  rp <= rp + 1'b1;
        end
    end

    a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(DEPTH));

    a_r7_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (level == (AW+1)'(DEPTH)));

endmodule

// File: rtl/ssm_engine.sv
`timescale 1ns/1ps
module ssm_engine
    import ssm_pkg::*;
#(
    parameter int W    = 16,
    parameter int DIVW = 8,
    parameter int CMDW = 8,
    parameter int MINB = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             cfg_fmt,
    input  logic [$clog2(W)-1:0]   cfg_size,
    input  logic [DIVW-1:0]        cfg_div,
    input  logic                   cfg_cpol,
    input  logic                   cfg_cpha,
    input  logic                   tx_valid,
    input  logic [W-1:0]           tx_word,
    output logic                   tx_pop,
    output logic                   rx_push,
    output logic [W-1:0]           rx_word,
    input  logic                   sin,
    output logic                   sclk,
    output logic                   sdo,
    output logic                   sfrm,
    output logic                   active
);
    localparam int SZW = $clog2(W);

    eng_state_e         st, st_nx;
    fmt_e               fmt_live, fmt_q;
    logic [SZW-1:0]     nb_live, nb_q, bitc;
    logic [DIVW-1:0]    hcnt, div_q;
    logic               ph, cpol_q, cpha_q;
    logic [W-1:0]       tx_sh, rx_sh;
    logic               in_bit, half_end, bit_end, rx_on, clk_act;

    assign fmt_live = decode_fmt(cfg_fmt);
    assign nb_live  = (cfg_size < SZW'(MINB-1)) ? SZW'(MINB-1) : cfg_size;
    assign in_bit   = (st == ST_PULSE) || (st == ST_SEND) ||
                      (st == ST_TURN)  || (st == ST_RECV);
    assign half_end = in_bit && (hcnt == div_q);
    assign bit_end  = half_end && ph;
    assign rx_on    = ((st == ST_SEND) && (fmt_q != FMT_MWIRE)) || (st == ST_RECV);
    assign tx_pop   = (st == ST_IDLE) && tx_valid;
    assign rx_push  = (st == ST_DONE);
    assign rx_word  = rx_sh;
    assign active   = (st != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (tx_valid) st_nx = (fmt_live == FMT_DSP) ? ST_PULSE : ST_SEND;
            ST_PULSE: if (bit_end) st_nx = ST_SEND;
            ST_SEND:  if (bit_end && bitc == '0)
                          st_nx = (fmt_q == FMT_MWIRE) ? ST_TURN : ST_DONE;
            ST_TURN:  if (bit_end) st_nx = ST_RECV;
            ST_RECV:  if (bit_end && bitc == '0) st_nx = ST_DONE;
            ST_DONE:  st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // datapath: divider, bit counter, shift registers, latched settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt   <= '0;
            ph     <= 1'b0;
            bitc   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            fmt_q  <= FMT_SPI;
            nb_q   <= SZW'(MINB-1);
            div_q  <= '0;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
        end else if (st == ST_IDLE) begin
            hcnt <= '0;
            ph   <= 1'b0;
            if (tx_valid) begin
                tx_sh  <= tx_word;
                rx_sh  <= '0;
                fmt_q  <= fmt_live;
                nb_q   <= nb_live;
                div_q  <= cfg_div;
                cpol_q <= cfg_cpol;
                cpha_q <= cfg_cpha;
                bitc   <= (fmt_live == FMT_MWIRE) ? SZW'(CMDW-1) : nb_live;
            end
        end else if (in_bit) begin
            if (half_end) begin
                hcnt <= '0;
                ph   <= ~ph;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
            if (half_end && !ph && rx_on)
                rx_sh <= {rx_sh[W-2:0], sin};
            if (bit_end) begin
                if (st == ST_TURN)
                    bitc <= nb_q;
                else if (((st == ST_SEND) || (st == ST_RECV)) && bitc != '0)
                    bitc <= bitc - 1'b1;
            end
        end
    end

    // clock level inside a bit, per format
    always_comb begin
        unique case (fmt_q)
            FMT_DSP:   clk_act = ~ph;
            FMT_MWIRE: clk_act = ph;
            default:   clk_act = cpol_q ^ (cpha_q ? ~ph : ph);
        endcase
    end

    // output process
    always_comb begin
        sclk = 1'b0;
        sdo  = 1'b0;
        sfrm = 1'b1;
        unique case (st)
            ST_IDLE: begin
                sclk = (fmt_live == FMT_SPI) && cfg_cpol;
                sfrm = (fmt_live != FMT_DSP);
            end
            ST_PULSE: begin
                sclk = clk_act;
                sfrm = 1'b1;
            end
            ST_SEND: begin
                sclk = clk_act;
                sdo  = tx_sh[bitc];
                sfrm = 1'b0;
            end
            ST_TURN, ST_RECV: begin
                sclk = clk_act;
                sfrm = 1'b0;
            end
            ST_DONE: begin
                sclk = (fmt_q == FMT_SPI) && cpol_q;
                sfrm = (fmt_q != FMT_DSP);
            end
            default: ;
        endcase
    end

    a_r8_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_bit |-> (hcnt <= div_q));

    a_r4_turn_to_recv: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TURN && bit_end) |=> (st == ST_RECV));

    a_r3_pulse_dsp_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PULSE) |-> (fmt_q == FMT_DSP));

    a_r4_recv_mwire_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RECV) |-> (fmt_q == FMT_MWIRE));

endmodule

// File: rtl/ssm_irq.sv
`timescale 1ns/1ps
module ssm_irq
    import ssm_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DIVW   = 8,
    parameter int TOBITS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH):0]   tx_level,
    input  logic [$clog2(DEPTH):0]   rx_level,
    input  logic                     rx_push,
    input  logic                     rx_pop,
    input  logic                     rx_full,
    input  logic [DIVW-1:0]          cfg_div,
    input  logic [NIRQ-1:0]          irq_en,
    input  logic                     ovr_clr,
    output logic [NIRQ-1:0]          irq,
    output logic                     irq_any
);
    localparam int LVLW = $clog2(DEPTH) + 1;
    localparam int SH   = $clog2(2*TOBITS);
    localparam int TW   = DIVW + SH + 1;

    logic [TW-1:0]   tcnt, lim;
    logic            ovr_q;
    logic [NIRQ-1:0] raw;

    assign lim = (TW'(cfg_div) + TW'(1)) << SH;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt  <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (rx_level == '0 || rx_push || rx_pop) tcnt <= '0;
            else if (tcnt < lim)                     tcnt <= tcnt + 1'b1;
            if (rx_push && rx_full) ovr_q <= 1'b1;
            else if (ovr_clr)       ovr_q <= 1'b0;
        end
    end

    always_comb begin
        raw             = '0;
        raw[IRQ_TXLOW]  = (tx_level <= LVLW'(DEPTH/2));
        raw[IRQ_RXHIGH] = (rx_level >= LVLW'(DEPTH/2));
        raw[IRQ_TOUT]   = (rx_level != '0) && (tcnt >= lim);
        raw[IRQ_OVR]    = ovr_q;
    end

    assign irq     = raw & irq_en;
    assign irq_any = |irq;

    a_r11_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[IRQ_OVR] && !ovr_clr) |=> raw[IRQ_OVR]);

    a_r10_tout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        raw[IRQ_TOUT] |-> (rx_level != '0));

    a_r9_any_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (irq_en != '0));

endmodule

// File: rtl/sync_serial_master.sv
`timescale 1ns/1ps
module sync_serial_master
    import ssm_pkg::*;
#(
    parameter int W      = 16,
    parameter int DEPTH  = 8,
    parameter int DIVW   = 8,
    parameter int CMDW   = 8,
    parameter int MINB   = 4,
    parameter int TOBITS = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_wr,
    input  logic [W-1:0]           tx_wdata,
    input  logic                   rx_rd,
    output logic [W-1:0]           rx_rdata,
    input  logic [1:0]             cfg_fmt,
    input  logic [$clog2(W)-1:0]   cfg_size,
    input  logic [DIVW-1:0]        cfg_div,
    input  logic                   cfg_cpol,
    input  logic                   cfg_cpha,
    input  logic                   cfg_loop,
    input  logic [3:0]             cfg_irq_en,
    input  logic                   ovr_clr,
    output logic                   sclk,
    output logic                   sdo,
    output logic                   sfrm,
    input  logic                   sdi,
    output logic                   st_tx_empty,
    output logic                   st_tx_not_full,
    output logic                   st_rx_not_empty,
    output logic                   st_rx_full,
    output logic                   st_busy,
    output logic [3:0]             irq,
    output logic                   irq_any
);
    localparam int LVLW = $clog2(DEPTH) + 1;

    logic [W-1:0]    tx_head, rx_word;
    logic [LVLW-1:0] tx_level, rx_level;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            tx_pop, rx_push, eng_active, sdo_i, sin;

    assign sin = cfg_loop ? sdo_i : sdi;
    assign sdo = sdo_i;

    ssm_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr), .din(tx_wdata),
        .pop(tx_pop), .dout(tx_head),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    ssm_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_word),
        .pop(rx_rd), .dout(rx_rdata),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    ssm_engine #(.W(W), .DIVW(DIVW), .CMDW(CMDW), .MINB(MINB)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .cfg_fmt(cfg_fmt), .cfg_size(cfg_size), .cfg_div(cfg_div),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .tx_valid(!tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word), .sin(sin),
        .sclk(sclk), .sdo(sdo_i), .sfrm(sfrm), .active(eng_active)
    );

    ssm_irq #(.DEPTH(DEPTH), .DIVW(DIVW), .TOBITS(TOBITS)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .rx_level(rx_level),
        .rx_push(rx_push), .rx_pop(rx_rd && !rx_empty), .rx_full(rx_full),
        .cfg_div(cfg_div), .irq_en(cfg_irq_en), .ovr_clr(ovr_clr),
        .irq(irq), .irq_any(irq_any)
    );

    assign st_tx_empty     = tx_empty;
    assign st_tx_not_full  = !tx_full;
    assign st_rx_not_empty = !rx_empty;
    assign st_rx_full      = rx_full;
    assign st_busy         = eng_active || !tx_empty;

    a_r12_pending_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty && !eng_active) |=> eng_active);

    a_r11_push_full_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_rd) |=> st_rx_full);

endmodule

// File: tb/sync_serial_master_bench.sv
`timescale 1ns/1ps
module sync_serial_master_bench;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [3:0]  size;
        logic [7:0]  div;
        logic        cpol;
        logic        cpha;
        logic        loop;
        logic [15:0] tx;
        logic [15:0] resp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 4'd7,  8'd1, 1'b0, 1'b0, 1'b1, 16'hA5C3, 16'h0000},
        '{2'd0, 4'd15, 8'd0, 1'b1, 1'b1, 1'b1, 16'h1234, 16'h0000},
        '{2'd0, 4'd3,  8'd2, 1'b0, 1'b0, 1'b1, 16'hFFF9, 16'h0000},
        '{2'd0, 4'd1,  8'd0, 1'b0, 1'b0, 1'b1, 16'h00AB, 16'h0000},
        '{2'd1, 4'd11, 8'd1, 1'b0, 1'b0, 1'b1, 16'hF5A7, 16'h0000},
        '{2'd1, 4'd4,  8'd0, 1'b0, 1'b0, 1'b1, 16'h0011, 16'h0000},
        '{2'd2, 4'd7,  8'd1, 1'b0, 1'b0, 1'b0, 16'h3C96, 16'h005A},
        '{2'd2, 4'd15, 8'd0, 1'b0, 1'b0, 1'b0, 16'h0001, 16'hBEEF},
        '{2'd0, 4'd9,  8'd0, 1'b0, 1'b1, 1'b1, 16'h02D6, 16'h0000},
        '{2'd0, 4'd5,  8'd3, 1'b1, 1'b0, 1'b1, 16'h0029, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_rdata;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [3:0]  cfg_size = 4'd7;
    logic [7:0]  cfg_div = 8'd0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_loop = 1'b0;
    logic [3:0]  cfg_irq_en = 4'd0;
    logic        ovr_clr = 1'b0;
    logic        sclk, sdo, sfrm;
    logic        sdi = 1'b0;
    logic        st_tx_empty, st_tx_not_full, st_rx_not_empty, st_rx_full, st_busy;
    logic [3:0]  irq;
    logic        irq_any;

    int          nchk = 0;
    int          nfail = 0;

    // monitor state
    logic [31:0] cap = '0;
    int          samp = 0;
    int          falls = 0;
    int          pw = 0;
    time         t1 = 0;
    time         t2 = 0;
    int          cur_nb = 8;
    logic [15:0] cur_resp = '0;

    always #4 clk = ~clk;

    sync_serial_master u_sync_serial_master (
        .clk(clk), .rst_n(rst_n),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .cfg_fmt(cfg_fmt), .cfg_size(cfg_size), .cfg_div(cfg_div),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_loop(cfg_loop),
        .cfg_irq_en(cfg_irq_en), .ovr_clr(ovr_clr),
        .sclk(sclk), .sdo(sdo), .sfrm(sfrm), .sdi(sdi),
        .st_tx_empty(st_tx_empty), .st_tx_not_full(st_tx_not_full),
        .st_rx_not_empty(st_rx_not_empty), .st_rx_full(st_rx_full),
        .st_busy(st_busy), .irq(irq), .irq_any(irq_any)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic take_bit();
        cap = {cap[30:0], sdo};
        samp++;
        if (samp == 1) t1 = $time;
        if (samp == 2) t2 = $time;
    endtask

    // sample-edge monitor: rising edges
    initial forever begin
        @(posedge sclk);
        if (sfrm == 1'b0 && (cfg_fmt == 2'd2 || (cfg_fmt == 2'd0 && cfg_cpol == cfg_cpha)))
            take_bit();
    end

    // sample-edge monitor: falling edges (format 0, polarity != phase)
    initial forever begin
        @(negedge sclk);
        if (sfrm == 1'b0 && cfg_fmt == 2'd0 && cfg_cpol != cfg_cpha)
            take_bit();
    end

    // reply driver for command/response frames
    initial forever begin
        @(negedge sclk);
        if (cfg_fmt == 2'd2 && sfrm == 1'b0) begin
            falls++;
            if (falls >= 9 && (falls - 9) < cur_nb)
                sdi = cur_resp[cur_nb - 1 - (falls - 9)];
        end
    end

    // frame-pulse width counter
    initial forever begin
        @(posedge clk);
        if (sfrm === 1'b1 && cfg_fmt == 2'd1) pw++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R12 watchdog actual=hang expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    task automatic push_word(input logic [15:0] w);
        tx_wdata = w;
        tx_wr    = 1'b1;
        @(negedge clk);
        tx_wr    = 1'b0;
    endtask

    task automatic pop_word();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_frame();
        do @(negedge clk); while (st_busy || !st_rx_not_empty);
    endtask

    initial begin
        logic [15:0] mask, expw;
        int nb;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx empty",     32'(st_tx_empty), 32'd1);
        chk("R1 tx not full",  32'(st_tx_not_full), 32'd1);
        chk("R1 rx not empty", 32'(st_rx_not_empty), 32'd0);
        chk("R1 rx full",      32'(st_rx_full), 32'd0);
        chk("R1 busy",         32'(st_busy), 32'd0);
        chk("R1 sclk idle",    32'(sclk), 32'd0);
        chk("R1 select idle",  32'(sfrm), 32'd1);
        chk("R1 irq_any",      32'(irq_any), 32'd0);

        // R9 mask and combined output with empty transmit queue
        cfg_irq_en = 4'b0001;
        @(negedge clk);
        chk("R9 tx low irq",  32'(irq), 32'h1);
        chk("R9 irq_any on",  32'(irq_any), 32'd1);
        cfg_irq_en = 4'b0000;
        @(negedge clk);
        chk("R9 masked",      32'(irq_any), 32'd0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            cfg_fmt  = VECS[i].fmt;
            cfg_size = VECS[i].size;
            cfg_div  = VECS[i].div;
            cfg_cpol = VECS[i].cpol;
            cfg_cpha = VECS[i].cpha;
            cfg_loop = VECS[i].loop;
            nb       = ((VECS[i].size < 4'd3) ? 3 : int'(VECS[i].size)) + 1;
            mask     = 16'((32'd1 << nb) - 1);
            cur_nb   = nb;
            cur_resp = VECS[i].resp;
            sdi      = 1'b0;
            @(negedge clk);
            cap = '0; samp = 0; falls = 0; pw = 0;
            push_word(VECS[i].tx);
            wait_frame();
            if (VECS[i].fmt == 2'd2) begin
                expw = VECS[i].resp & mask;
                chk($sformatf("R4 reply word v%0d", i), 32'(rx_rdata), 32'(expw));
                chk($sformatf("R4 command v%0d", i), (cap >> (nb + 1)) & 32'hFF, 32'(VECS[i].tx[7:0]));
                chk($sformatf("R4 edge count v%0d", i), 32'(samp), 32'(9 + nb));
            end else begin
                expw = VECS[i].tx & mask;
                chk($sformatf("R6 R5 loopback word v%0d", i), 32'(rx_rdata), 32'(expw));
            end
            if (VECS[i].fmt == 2'd0) begin
                chk($sformatf("R2 msb-first bits v%0d", i), cap & 32'(mask), 32'(expw));
                chk($sformatf("R2 edge count v%0d", i), 32'(samp), 32'(nb));
                chk($sformatf("R2 clock idle v%0d", i), 32'(sclk), 32'(VECS[i].cpol));
                chk($sformatf("R8 bit period v%0d", i), 32'(t2 - t1), 32'(16 * (int'(VECS[i].div) + 1)));
            end
            if (VECS[i].fmt == 2'd1) begin
                chk($sformatf("R3 pulse width v%0d", i), 32'(pw), 32'(2 * (int'(VECS[i].div) + 1)));
                chk($sformatf("R3 frame idle v%0d", i), 32'(sfrm), 32'd0);
            end
            pop_word();
        end

        // R7 R11 R12 burst: ten writes, 4-bit frames, fastest clock
        cfg_fmt = 2'd0; cfg_size = 4'd3; cfg_div = 8'd0;
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_loop = 1'b1;
        cfg_irq_en = 4'b1111;
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            tx_wdata = 16'(k + 1);
            tx_wr    = 1'b1;
            @(negedge clk);
        end
        tx_wr = 1'b0;
        chk("R7 tx queue full", 32'(st_tx_not_full), 32'd0);
        chk("R12 busy",         32'(st_busy), 32'd1);
        chk("R9 tx low clear",  32'(irq[0]), 32'd0);
        do @(negedge clk); while (st_busy);
        chk("R7 rx full",       32'(st_rx_full), 32'd1);
        chk("R11 overrun set",  32'(irq[3]), 32'd1);
        chk("R9 rx high set",   32'(irq[1]), 32'd1);
        for (int k = 0; k < 8; k++) begin
            chk($sformatf("R12 R11 burst word %0d", k), 32'(rx_rdata), 32'(k + 1));
            pop_word();
        end
        chk("R11 ninth discarded", 32'(st_rx_not_empty), 32'd0);
        chk("R9 rx high clear",    32'(irq[1]), 32'd0);
        chk("R11 overrun sticky",  32'(irq[3]), 32'd1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk("R11 overrun cleared", 32'(irq[3]), 32'd0);

        // R10 receive timeout: divider 1 gives 128 quiet cycles
        cfg_div = 8'd1;
        @(negedge clk);
        push_word(16'h0005);
        do @(negedge clk); while (!st_rx_not_empty);
        repeat (120) @(negedge clk);
        chk("R10 timeout early", 32'(irq[2]), 32'd0);
        repeat (10) @(negedge clk);
        chk("R10 timeout fired", 32'(irq[2]), 32'd1);
        pop_word();
        chk("R10 timeout clears", 32'(irq[2]), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule